// File: doc/BRIEF.md
# Calibration Pulse Steering Controller

This block sets when and how a charge-injection calibration pulse is applied to a bank of readout channels. An external strobe, which may arrive asynchronously, marks the pulse window. The window only opens while the chip is in calibrate mode. During the window, every channel whose select bit is set gets an injection enable. The polarity and the two amplitude codes for the high and low calibration voltages go out beside the pulse.

The pulse polarity comes from the electrons/holes operating mode. There is no separate control for it. The polarity and both amplitude codes are captured only between pulses, so they stay fixed for the whole length of a pulse. A free-running counter counts the pulses issued. The strobe, the mode flags and the codes are plain level controls, so the block has no streaming interface and no back-pressure.

Top module: `cal_steer`

## Requirements
- R1: `inject_en_o[i]` is 1 exactly when `pulse_active_o` is 1 and `ch_sel_i[i]` is 1. In every other cycle all enable bits are 0.
- R2: While no pulse is active or starting, `amp_hi_o` and `amp_lo_o` equal the values `amp_hi_i` and `amp_lo_i` had at the previous rising clock edge.
- R3: While `cal_mode_i` is 0, `val_i` has no effect: `pulse_active_o`, `inject_en_o` and `pulse_count_o` do not respond to it. If `cal_mode_i` drops during a pulse, the pulse ends at the next clock edge.
- R4: When calibrate mode is on, `pulse_active_o` rises at the third rising edge after `val_i` rises. It stays high for as many cycles as `val_i` was high.
- R5: `polarity_o` is 0 (electrons) when `holes_mode_i` is 0 and 1 (holes) when `holes_mode_i` is 1.
- R6: `polarity_o`, `amp_hi_o` and `amp_lo_o` do not change while `pulse_active_o` stays high, even if their inputs change.
- R7: While `rst_n` is low, `pulse_active_o`, `polarity_o`, `amp_hi_o`, `amp_lo_o`, `inject_en_o` and `pulse_count_o` are all 0.
- R8: `pulse_count_o` goes up by exactly one, with wrap-around, in the cycle where `pulse_active_o` rises. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_mode_i | input | 1 | Calibrate mode enable |
| holes_mode_i | input | 1 | 0 = electrons mode, 1 = holes mode |
| val_i | input | 1 | Asynchronous calibration strobe |
| ch_sel_i | input | NUM_CH | Per-channel calibrate select |
| amp_hi_i | input | AMP_W | High-level amplitude code |
| amp_lo_i | input | AMP_W | Low-level amplitude code |
| pulse_active_o | output | 1 | Calibration pulse in progress |
| polarity_o | output | 1 | Pulse polarity, 0 electrons / 1 holes |
| amp_hi_o | output | AMP_W | Captured high-level code |
| amp_lo_o | output | AMP_W | Captured low-level code |
| inject_en_o | output | NUM_CH | Per-channel injection enable |
| pulse_count_o | output | CNT_W | Count of pulses issued |

## Verification
Strobes of different lengths, down to one cycle, are sent with different channel-select patterns and with both polarity modes. These runs separate a correct pulse length and channel steering from an off-by-one delay or a wrong mask. A strobe sent with calibrate mode off, and a pulse cut short by dropping calibrate mode, show whether the mode gate really controls the output. A pulse whose amplitude and polarity inputs change partway through shows whether the captured codes freeze for the pulse and load again afterwards.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic {
    POL_ELECTRON = 1'b0,
    POL_HOLE     = 1'b1
  } cal_pol_e;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/cal_hold.sv
module cal_hold
  import cal_pkg::*;
#(
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             holes_i,
  input  logic [AMP_W-1:0] hi_i,
  input  logic [AMP_W-1:0] lo_i,
  output cal_pol_e         pol_o,
  output logic [AMP_W-1:0] hi_o,
  output logic [AMP_W-1:0] lo_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_o <= POL_ELECTRON;
      hi_o  <= '0;
      lo_o  <= '0;
    end else if (load_i) begin
      pol_o <= holes_i ? POL_HOLE : POL_ELECTRON;
      hi_o  <= hi_i;
      lo_o  <= lo_i;
    end
  end

  // R6: no reload while the pulse is starting or running
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(hi_o) && $stable(lo_o) && $stable(pol_o)));

  // R2 / R5: a load captures the inputs
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (hi_o == $past(hi_i) && lo_o == $past(lo_i)
                && pol_o == cal_pol_e'($past(holes_i))));
endmodule

// File: rtl/cal_gate.sv
module cal_gate #(
  parameter int NUM_CH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [NUM_CH-1:0] sel_i,
  output logic [NUM_CH-1:0] en_o
);
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_o[ch] <= 1'b0;
        else        en_o[ch] <= fire_i & sel_i[ch];
      end
    end
  endgenerate

  // R1: no channel is enabled once the fire request is gone
  assert_idle_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> (en_o == '0));
endmodule

// File: rtl/cal_pulse_cnt.sv
module cal_pulse_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (rise_i) count_o <= count_o + ONE;
  end

  // R8: counter moves only on a pulse start
  assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(count_o));
endmodule

// File: rtl/cal_steer.sv
module cal_steer
  import cal_pkg::*;
#(
  parameter int NUM_CH      = 128,
  parameter int AMP_W       = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_mode_i,
  input  logic              holes_mode_i,
  input  logic              val_i,
  input  logic [NUM_CH-1:0] ch_sel_i,
  input  logic [AMP_W-1:0]  amp_hi_i,
  input  logic [AMP_W-1:0]  amp_lo_i,
  output logic              pulse_active_o,
  output logic              polarity_o,
  output logic [AMP_W-1:0]  amp_hi_o,
  output logic [AMP_W-1:0]  amp_lo_o,
  output logic [NUM_CH-1:0] inject_en_o,
  output logic [CNT_W-1:0]  pulse_count_o
);
  logic     val_sync;
  logic     fire;
  logic     pulse_q;
  logic     pulse_rise;
  cal_pol_e pol_q;

  cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (val_i),
    .q_o   (val_sync)
  );

  // pulse request for the coming cycle
  assign fire       = val_sync & cal_mode_i;
  assign pulse_rise = fire & ~pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end

  cal_hold #(.AMP_W(AMP_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (~fire),
    .holes_i (holes_mode_i),
    .hi_i    (amp_hi_i),
    .lo_i    (amp_lo_i),
    .pol_o   (pol_q),
    .hi_o    (amp_hi_o),
    .lo_o    (amp_lo_o)
  );

  cal_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .sel_i  (ch_sel_i),
    .en_o   (inject_en_o)
  );

  cal_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (pulse_rise),
    .count_o (pulse_count_o)
  );

  assign pulse_active_o = pulse_q;
  assign polarity_o     = pol_q;

  // R3: mode off means no pulse in the next cycle
  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode_i |=> !pulse_active_o);

  // R1: enables only appear under an active pulse
  assert_inject_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_active_o |-> (inject_en_o == '0));

  // R6: codes frozen across consecutive pulse cycles
  assert_codes_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_active_o && $past(pulse_active_o)) |->
      ($stable(amp_hi_o) && $stable(amp_lo_o) && $stable(polarity_o)));

  // R8: count steps by one as the pulse starts
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active_o) |-> (pulse_count_o == $past(pulse_count_o) + CNT_W'(1)));
endmodule

// File: tb/cal_steer_tb.sv
module cal_steer_tb;
  localparam int NUM_CH = 128;
  localparam int AMP_W  = 8;
  localparam int CNT_W  = 16;

  typedef struct {
    logic              pol;
    logic [AMP_W-1:0]  hi;
    logic [AMP_W-1:0]  lo;
    logic [NUM_CH-1:0] sel;
    int                len;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cal_mode = 1'b0;
  logic              holes = 1'b0;
  logic              val = 1'b0;
  logic [NUM_CH-1:0] sel = '0;
  logic [AMP_W-1:0]  hi_in = '0;
  logic [AMP_W-1:0]  lo_in = '0;
  logic              pulse;
  logic              pol;
  logic [AMP_W-1:0]  hi_out;
  logic [AMP_W-1:0]  lo_out;
  logic [NUM_CH-1:0] inj;
  logic [CNT_W-1:0]  cnt;

  int   tests = 0;
  int   fails = 0;
  int   seen  = 0;
  int   cycles = 0;
  exp_t q[$];
  exp_t cur;
  int   cur_len = 0;
  logic prev = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cal_steer #(.NUM_CH(NUM_CH), .AMP_W(AMP_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_mode_i(cal_mode), .holes_mode_i(holes),
    .val_i(val), .ch_sel_i(sel), .amp_hi_i(hi_in), .amp_lo_i(lo_in),
    .pulse_active_o(pulse), .polarity_o(pol), .amp_hi_o(hi_out),
    .amp_lo_o(lo_out), .inject_en_o(inj), .pulse_count_o(cnt)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [NUM_CH-1:0] act, input logic [NUM_CH-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: queue the expected pulse, then play the strobe
  task automatic send(input int len, input logic h, input logic [AMP_W-1:0] a,
                      input logic [AMP_W-1:0] b, input logic [NUM_CH-1:0] s);
    exp_t e;
    e.pol = h; e.hi = a; e.lo = b; e.sel = s; e.len = len;
    q.push_back(e);
    holes = h; hi_in = a; lo_in = b; sel = s;
    val = 1'b1;
    step(len);
    val = 1'b0;
    step(6);
  endtask

  // monitor: compare each pulse as it appears
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pulse && !prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected pulse", '1, '0);
          cur = '{pol: 1'b0, hi: '0, lo: '0, sel: '0, len: 0};
        end else begin
          cur = q.pop_front();
          seen++;
          check(cnt == CNT_W'(seen), "R8", "pulse count", cnt, CNT_W'(seen));
        end
        cur_len = 1;
      end else if (pulse) begin
        cur_len++;
      end else if (prev) begin
        check(cur_len == cur.len, "R4", "pulse length", cur_len, cur.len);
      end
      if (pulse) begin
        check(inj == cur.sel, "R1", "inject mask", inj, cur.sel);
        check(pol == cur.pol, "R5", "polarity", pol, cur.pol);
        check(hi_out == cur.hi && lo_out == cur.lo, "R6", "codes in pulse",
              {hi_out, lo_out}, {cur.hi, cur.lo});
      end else begin
        check(inj == '0, "R1", "idle inject", inj, '0);
      end
      prev = pulse;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] pat_a;
    logic [NUM_CH-1:0] pat_b;
    logic [CNT_W-1:0]  c0;
    pat_a = {NUM_CH/2{2'b01}};
    pat_b = '0;
    pat_b[0] = 1'b1;
    pat_b[NUM_CH-1] = 1'b1;

    // R7: reset state, with live inputs
    hi_in = 8'hA5; lo_in = 8'h3C; holes = 1'b1; sel = '1; cal_mode = 1'b1; val = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(pulse == 1'b0 && pol == 1'b0 && cnt == '0, "R7", "reset ctrl",
          {pulse, pol, cnt}, '0);
    check(hi_out == '0 && lo_out == '0 && inj == '0, "R7", "reset data",
          {hi_out, lo_out}, '0);
    val = 1'b0;
    rst_n = 1'b1;
    step(5);

    // R2: idle capture of codes
    hi_in = 8'h12; lo_in = 8'h34; holes = 1'b0;
    step(1);
    check(hi_out == 8'h12 && lo_out == 8'h34, "R2", "idle capture",
          {hi_out, lo_out}, {8'h12, 8'h34});

    // R1 R4 R5: pulses of various lengths, patterns and polarities
    send(4, 1'b0, 8'h80, 8'h10, pat_a);
    send(1, 1'b1, 8'hFF, 8'h00, pat_b);
    send(7, 1'b1, 8'h40, 8'h20, '1);
    send(2, 1'b0, 8'h01, 8'hFE, ~pat_a);

    // R3: strobe with calibrate mode off
    c0 = cnt;
    cal_mode = 1'b0;
    val = 1'b1;
    step(8);
    check(pulse == 1'b0 && inj == '0, "R3", "mode off output", {pulse, inj}, '0);
    val = 1'b0;
    step(5);
    check(cnt == c0, "R3", "mode off count", cnt, c0);
    cal_mode = 1'b1;
    step(2);

    // R6: inputs change in the middle of a pulse
    begin
      exp_t e;
      e.pol = 1'b0; e.hi = 8'h55; e.lo = 8'h66; e.sel = pat_b; e.len = 10;
      q.push_back(e);
      holes = 1'b0; hi_in = 8'h55; lo_in = 8'h66; sel = pat_b;
      val = 1'b1;
      step(5);
      holes = 1'b1; hi_in = 8'hC3; lo_in = 8'h9A;
      step(5);
      val = 1'b0;
      step(6);
      check(hi_out == 8'hC3 && lo_out == 8'h9A && pol == 1'b1, "R6",
            "reload after pulse", {pol, hi_out, lo_out}, {1'b1, 8'hC3, 8'h9A});
    end

    // R3: dropping calibrate mode cuts the pulse at the next edge
    begin
      exp_t e;
      e.pol = 1'b1; e.hi = 8'h77; e.lo = 8'h11; e.sel = pat_a; e.len = 3;
      q.push_back(e);
      holes = 1'b1; hi_in = 8'h77; lo_in = 8'h11; sel = pat_a;
      val = 1'b1;
      step(5);
      cal_mode = 1'b0;
      step(1);
      check(pulse == 1'b0 && inj == '0, "R3", "mode drop ends pulse", {pulse, inj}, '0);
      step(3);
      val = 1'b0;
      step(5);
      cal_mode = 1'b1;
      step(2);
    end

    // R8: back-to-back short pulses
    for (int i = 0; i < 5; i++) send(1 + i, i[0], 8'(i * 17), 8'(255 - i), pat_a ^ NUM_CH'(i));

    step(4);
    check(q.size() == 0, "R8", "all pulses seen", q.size(), 0);
    check(cnt == CNT_W'(seen), "R8", "final count", cnt, CNT_W'(seen));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule